// File: doc/BRIEF.md
# Nesting Maskable Interrupt Controller

This block collects four interrupt sources and turns them into a single vectored request to a processor core. The sources are two external pins, each active on an edge, a timer overflow pulse, and an event pulse from an oscillation converter. Each source has an enable bit and a request flag, and a global enable sits beside them. All of these are held in two 8-bit control registers that software can read and write. A flag is set whenever its source fires, whatever the enables hold. A request goes to the core only when at least one flag is set together with its enable, the global enable is set, and the return stack is not full.

When the core acknowledges a request, the controller clears the global enable and the flag of the source that won. Further interrupts are then blocked until software sets the global enable again. A service routine can set it itself to allow nesting. Each source has its own vector address. Any enabled pending flag also drives a wake-up output, which the core uses to leave a halted state.

Top module: `nest_intc`

## Requirements
- R1: After reset both control registers read 0x00, and `vec_req_o` and `wake_o` are low.
- R2: Register 0 holds the global enable in bit 0, the enables for ext0, ext1 and timer in bits 1, 2 and 3, and the flags for ext0, ext1 and timer in bits 4, 5 and 6. Bit 7 reads 0. Register 1 holds the converter enable in bit 0 and the converter flag in bit 4, and its other bits read 0. Writes take effect on the next clock edge.
- R3: `vec_req_o` is high exactly when the global enable is set, `stack_full_i` is low, and at least one source has both its flag and its enable set.
- R4: When several requests are pending, the winner is chosen by the fixed priority ext0, then timer, then ext1, then converter. `vec_addr_o` equals VEC_BASE + VEC_STEP*k, with k = 0 for ext0, 1 for ext1, 2 for timer and 3 for converter.
- R5: Flags are set when their event occurs whatever the global and individual enables hold, and they stay set until they are acknowledged or written.
- R6: An acknowledge while `vec_req_o` is high clears the global enable and the winner's flag on that edge, and leaves the other flags unchanged. An acknowledge while `vec_req_o` is low has no effect.
- R7: An event from the winning source in the same cycle as its acknowledge leaves that source's flag set.
- R8: Each external pin passes through a two-stage synchronizer. `ext_rise_i[n]` = 1 selects the rising edge and 0 selects the falling edge. The active edge sets the flag on the third rising clock edge after the pin changes. The opposite edge sets nothing.
- R9: A one-cycle `tmr_ovf_i` or `cnv_evt_i` pulse sets the flag of that source on the next clock edge.
- R10: While `stack_full_i` is high no request is raised. The pending request appears as soon as `stack_full_i` falls.
- R11: `wake_o` is high whenever any flag is set together with its enable, whatever the global enable and the stack state.
- R12: After an acknowledge, software can set the global enable again to let the next pending enabled source request (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 2 | External interrupt pins (asynchronous) |
| ext_rise_i | input | 2 | Static edge select per pin, 1 = rising |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| cnv_evt_i | input | 1 | Oscillation converter event pulse |
| stack_full_i | input | 1 | Return stack full |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select, 0 = register 0, 1 = register 1 |
| reg_wdata_i | input | 8 | Register write data |
| ctrl0_o | output | 8 | Register 0 readback |
| ctrl1_o | output | 8 | Register 1 readback |
| vec_req_o | output | 1 | Vector request to the core |
| vec_addr_o | output | VEC_W | Vector address of the winning source |
| vec_ack_i | input | 1 | Core acknowledge |
| wake_o | output | 1 | Wake-up indication |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 12-bit vector, base 4 and step 4. Under these settings each source has its own address (4, 8, 12, 16), so every priority outcome can be told apart on `vec_addr_o`. The synchronizer depth fixes the three-edge pin latency, which the bench checks one cycle early and again exactly on time. Register-driven pending patterns reach every priority pairing, and directed sequences cover acknowledge, nesting, stack hold-off and an event that collides with an acknowledge.

// File: rtl/nintc_pkg.sv
package nintc_pkg;
  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    SRC_EXT0 = 2'd0,
    SRC_EXT1 = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_CNV  = 2'd3
  } src_e;

  // highest priority first
  localparam src_e PRIO_ORDER [NSRC] = '{SRC_EXT0, SRC_TMR, SRC_EXT1, SRC_CNV};

  // field positions
  localparam int GIE_BIT  = 0;
  localparam int EN0_LO   = 1;  // reg0 enables, sources 0..2
  localparam int FLAG0_LO = 4;  // reg0 flags, sources 0..2
  localparam int EN1_BIT  = 0;  // reg1 converter enable
  localparam int FLAG1_BIT = 4; // reg1 converter flag
  localparam int REG0_SRCS = 3;
endpackage

// File: rtl/nintc_edge_det.sv
module nintc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic             norm;
  logic [STAGES-1:0] sync_q;
  logic             last_q;

  // active level mapped to 1 so reset to 0 is always the idle level
  assign norm = pin_i ^ ~rise_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], norm};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign evt_o = sync_q[STAGES-1] & ~last_q;

  AST_EDGE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R8
endmodule

// File: rtl/nintc_prio.sv
module nintc_prio
  import nintc_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] grant_o,
  output src_e            idx_o,
  output logic            any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = SRC_EXT0;
    any_o   = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (!any_o && pend_i[PRIO_ORDER[k]]) begin
        grant_o[PRIO_ORDER[k]] = 1'b1;
        idx_o = PRIO_ORDER[k];
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nintc_regs.sv
module nintc_regs
  import nintc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [7:0]      wdata_i,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            gie_clr_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] flag_o,
  output logic            gie_o,
  output logic [7:0]      ctrl0_o,
  output logic [7:0]      ctrl1_o
);
  logic            wr0, wr1;
  logic [NSRC-1:0] wr_hit, wr_en_bit, wr_flag_bit;
  logic [NSRC-1:0] en_q, en_d, flag_q, flag_d;
  logic            gie_q, gie_d;

  assign wr0 = we_i & ~sel_i;
  assign wr1 = we_i & sel_i;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_map
      if (i < REG0_SRCS) begin : g_r0
        assign wr_hit[i]      = wr0;
        assign wr_en_bit[i]   = wdata_i[EN0_LO+i];
        assign wr_flag_bit[i] = wdata_i[FLAG0_LO+i];
      end else begin : g_r1
        assign wr_hit[i]      = wr1;
        assign wr_en_bit[i]   = wdata_i[EN1_BIT];
        assign wr_flag_bit[i] = wdata_i[FLAG1_BIT];
      end
    end
  endgenerate

  // order: software write, then acknowledge clear, then hardware event
  always_comb begin
    gie_d = wr0 ? wdata_i[GIE_BIT] : gie_q;
    if (gie_clr_i) gie_d = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      en_d[i]   = wr_hit[i] ? wr_en_bit[i] : en_q[i];
      flag_d[i] = ((wr_hit[i] ? wr_flag_bit[i] : flag_q[i]) & ~clr_i[i]) | evt_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign gie_o   = gie_q;
  assign ctrl0_o = {1'b0, flag_q[REG0_SRCS-1:0], en_q[REG0_SRCS-1:0], gie_q};
  assign ctrl1_o = {3'b000, flag_q[NSRC-1], 3'b000, en_q[NSRC-1]};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> flag_q[i]); // R7
      AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_hit[i] && !clr_i[i] && !evt_i[i]) |=> $stable(flag_q[i])); // R5
    end
  endgenerate
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nintc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 12,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ext_pin_i,
  input  logic [1:0]       ext_rise_i,
  input  logic             tmr_ovf_i,
  input  logic             cnv_evt_i,
  input  logic             stack_full_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       ctrl0_o,
  output logic [7:0]       ctrl1_o,
  output logic             vec_req_o,
  output logic [VEC_W-1:0] vec_addr_o,
  input  logic             vec_ack_i,
  output logic             wake_o
);
  localparam int NEXT = 2;

  logic [NEXT-1:0] ext_evt;
  logic [NSRC-1:0] evt, en, flag, pend, grant, clr;
  logic            gie, any_pend, take;
  src_e            win_idx;

  generate
    for (genvar p = 0; p < NEXT; p++) begin : g_ext
      nintc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (ext_pin_i[p]),
        .rise_sel_i (ext_rise_i[p]),
        .evt_o      (ext_evt[p])
      );
    end
  endgenerate

  always_comb begin
    evt = '0;
    evt[SRC_EXT0] = ext_evt[0];
    evt[SRC_EXT1] = ext_evt[1];
    evt[SRC_TMR]  = tmr_ovf_i;
    evt[SRC_CNV]  = cnv_evt_i;
  end

  nintc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .evt_i     (evt),
    .clr_i     (clr),
    .gie_clr_i (take),
    .en_o      (en),
    .flag_o    (flag),
    .gie_o     (gie),
    .ctrl0_o   (ctrl0_o),
    .ctrl1_o   (ctrl1_o)
  );

  assign pend = flag & en;

  nintc_prio u_prio (
    .pend_i  (pend),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_pend)
  );

  assign vec_req_o  = gie & ~stack_full_i & any_pend;
  assign take       = vec_ack_i & vec_req_o;
  assign clr        = take ? grant : '0;
  assign wake_o     = any_pend;
  assign vec_addr_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_idx);

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R4
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> !vec_req_o); // R10
  AST_REQ_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> wake_o); // R11
  AST_ACK_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && vec_req_o) |=> !ctrl0_o[GIE_BIT]); // R6
  AST_NO_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && !vec_req_o && !reg_we_i) |=> $stable(ctrl0_o[GIE_BIT])); // R6
endmodule

// File: tb/nest_intc_test.sv
`timescale 1ns/1ps
module nest_intc_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ext_pin = 2'b10;
  logic [1:0]  ext_rise = 2'b01;
  logic        tmr_ovf = 1'b0, cnv_evt = 1'b0, stack_full = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  ctrl0, ctrl1;
  logic        vec_req, vec_ack = 1'b0, wake;
  logic [11:0] vec_addr;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  nest_intc uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_pin_i(ext_pin), .ext_rise_i(ext_rise),
    .tmr_ovf_i(tmr_ovf), .cnv_evt_i(cnv_evt), .stack_full_i(stack_full),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .vec_req_o(vec_req), .vec_addr_o(vec_addr),
    .vec_ack_i(vec_ack), .wake_o(wake)
  );

  // {c0[30:23], c1[22:15], full[14], req[13], wake[12], addr[11:0]}
  localparam int NV = 12;
  localparam logic [30:0] TBL [NV] = '{
    {8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 12'd0},   // R3 nothing pending
    {8'h13, 8'h00, 1'b0, 1'b1, 1'b1, 12'd4},   // R3 ext0
    {8'h7F, 8'h11, 1'b0, 1'b1, 1'b1, 12'd4},   // R4 all -> ext0
    {8'h6D, 8'h00, 1'b0, 1'b1, 1'b1, 12'd12},  // R4 timer over ext1
    {8'h25, 8'h11, 1'b0, 1'b1, 1'b1, 12'd8},   // R4 ext1 over converter
    {8'h01, 8'h11, 1'b0, 1'b1, 1'b1, 12'd16},  // R4 converter alone
    {8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 12'd0},   // R3 flag without enable
    {8'h12, 8'h00, 1'b0, 1'b0, 1'b1, 12'd0},   // R11 wake with gie clear
    {8'h13, 8'h00, 1'b1, 1'b0, 1'b1, 12'd0},   // R10 stack full
    {8'h21, 8'h00, 1'b0, 1'b0, 1'b0, 12'd0},   // R3 ext1 disabled
    {8'h00, 8'h10, 1'b0, 1'b0, 1'b0, 12'd0},   // R3 converter disabled
    {8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 12'd4}    // R2 unused bits read 0
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl0 in reset", ctrl0, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ctrl0", ctrl0, 0);
    chk("R1 ctrl1", ctrl1, 0);
    chk("R1 req", vec_req, 0);
    chk("R1 wake", wake, 0);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, TBL[i][30:23]);
      wr(1'b1, TBL[i][22:15]);
      stack_full = TBL[i][14];
      @(negedge clk);
      chk("R2 ctrl0 readback", ctrl0, int'(TBL[i][30:23] & 8'h7F));
      chk("R2 ctrl1 readback", ctrl1, int'(TBL[i][22:15] & 8'h11));
      chk("R3 req", vec_req, int'(TBL[i][13]));
      chk("R11 wake", wake, int'(TBL[i][12]));
      if (TBL[i][13]) chk("R4 addr", vec_addr, int'(TBL[i][11:0]));
      stack_full = 1'b0;
    end

    // R9 timer pulse, then R6 acknowledge
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h09);
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    chk("R9 timer flag", ctrl0, 8'h49);
    chk("R9 timer addr", vec_addr, 12);
    ack();
    chk("R6 ack clears gie and flag", ctrl0, 8'h08);
    chk("R6 req after ack", vec_req, 0);

    // R6 other flags kept, R12 nesting
    wr(1'b0, 8'h49);
    wr(1'b1, 8'h11);
    ack();
    chk("R6 ctrl0 after ack", ctrl0, 8'h08);
    chk("R6 converter flag kept", ctrl1, 8'h11);
    wr(1'b0, 8'h09);
    chk("R12 nested req", vec_req, 1);
    chk("R12 nested addr", vec_addr, 16);

    // R6 ack without request ignored
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h12);
    ack();
    chk("R6 idle ack ignored", ctrl0, 8'h12);

    // R7 event collides with acknowledge
    wr(1'b0, 8'h49);
    @(negedge clk); vec_ack = 1'b1; tmr_ovf = 1'b1;
    @(negedge clk); vec_ack = 1'b0; tmr_ovf = 1'b0;
    chk("R7 flag re-set", ctrl0, 8'h48);

    // R8 ext0 rising edge, three-edge latency
    wr(1'b0, 8'h03);
    @(negedge clk); ext_pin[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 ext0 not yet", ctrl0, 8'h03);
    @(negedge clk);
    chk("R8 ext0 flag", ctrl0, 8'h13);
    chk("R8 ext0 addr", vec_addr, 4);
    wr(1'b0, 8'h03);
    ext_pin[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 falling ignored on ext0", ctrl0, 8'h03);

    // R8 ext1 falling edge
    wr(1'b0, 8'h05);
    @(negedge clk); ext_pin[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 ext1 falling flag", ctrl0, 8'h25);
    chk("R8 ext1 addr", vec_addr, 8);
    wr(1'b0, 8'h05);
    ext_pin[1] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 rising ignored on ext1", ctrl0, 8'h05);

    // R10 release
    wr(1'b0, 8'h13);
    stack_full = 1'b1;
    @(negedge clk);
    chk("R10 held", vec_req, 0);
    stack_full = 1'b0;
    #1;
    chk("R10 released", vec_req, 1);

    // R5 flag set with everything disabled, held
    wr(1'b0, 8'h00);
    @(negedge clk); cnv_evt = 1'b1;
    @(negedge clk); cnv_evt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 converter flag held", ctrl1, 8'h10);
    chk("R5 no req", vec_req, 0);
    chk("R9 converter wake off", wake, 0);

    finish_run();
  end
endmodule